// File: doc/BRIEF.md
# Security-Gated Region Register Bank

This block is the software-visible storage for a memory security attribution unit. It holds a two-bit control field, a read-only type register that reports how many regions were built, a region selector, and one base-address word and one limit-address word for each region. The per-region words are not mapped one after another. Software first writes the region number into the selector, then reaches that region's base and limit words through two fixed offsets.

Every access must carry the secure attribute. Without it, reads return zero and writes are dropped. The block only stores and returns values. Its single link to the region-matching logic is a one-cycle pulse after each accepted base or limit update, which tells downstream caches of attribution results that they are stale. The `NUM_REGIONS` parameter sets the region count, from 0 to 255. With a count of zero no base or limit storage is built.

Top module: `sau_reg_bank`

## Requirements
- R1: The bus offset is a word offset. The registers decode at word 0x374 (control), 0x375 (type), 0x376 (region selector), 0x377 (region base) and 0x378 (region limit), which are byte offsets 0xDD0 to 0xDE0.
- R2: A read with `bus_secure` low returns zero. A write with `bus_secure` low changes no register and raises no pulse.
- R3: A secure control write stores only data bits [1:0]. Control reads return those bits with bits [31:2] at zero.
- R4: The type register reads as `NUM_REGIONS` in bits [7:0]. Writes to it change nothing.
- R5: A secure selector write with a value of at least `NUM_REGIONS` is discarded, so the selector keeps its previous value, and `sel_error` is high for the one cycle after the write edge. An in-range value is stored and reads back.
- R6: Base and limit accesses act on the region named by the current selector. Each region keeps its own values.
- R7: A base write stores the data with bits [4:0] cleared. A limit write stores the data with bits [4:2] cleared and bits [1:0] and [31:5] kept.
- R8: After reset the control field, the selector and every base and limit word are zero, and all pulse and flag outputs are low.
- R9: An accepted secure base or limit write raises `region_changed` for exactly the one cycle after the write edge. No other access raises it.
- R10: Any read or write to an offset outside the five registers returns zero data and raises `bad_offset` in the same cycle.
- R11: With zero regions, type reads zero, base and limit reads return zero, base and limit writes never raise `region_changed`, and every selector write is rejected with `sel_error`.
- R12: Read data is combinational and valid in the same cycle as `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_off | input | OFF_W | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access carries the secure attribute |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| bad_offset | output | 1 | Access to an unmapped offset |
| region_changed | output | 1 | One-cycle pulse after an accepted base or limit write |
| sel_error | output | 1 | One-cycle pulse after a rejected selector write |

## Verification
The embedded properties assume that `bus_rd` and `bus_wr` are never high together and that every input is settled before the clock edge. The properties that use `$past` also assume the bus is idle while reset is held. The stimulus keeps to these assumptions: a single task drives one access at a time shortly after a rising edge, and the bus stays idle during reset. A second instance built with zero regions shares the same inputs, so every access also exercises the empty configuration.

// File: rtl/sau_reg_bank.sv
module sau_reg_bank #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned OFF_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [OFF_W-1:0] bus_off,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_secure,
  output logic [31:0]      bus_rdata,
  output logic             bad_offset,
  output logic             region_changed,
  output logic             sel_error
);

  localparam int unsigned SEL_W = 8;
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [OFF_W-1:0] OFF_CTRL  = OFF_W'(10'h374);
  localparam logic [OFF_W-1:0] OFF_TYPE  = OFF_W'(10'h375);
  localparam logic [OFF_W-1:0] OFF_SEL   = OFF_W'(10'h376);
  localparam logic [OFF_W-1:0] OFF_BASE  = OFF_W'(10'h377);
  localparam logic [OFF_W-1:0] OFF_LIMIT = OFF_W'(10'h378);
  localparam logic [31:0] BASE_KEEP  = 32'hFFFF_FFE0;
  localparam logic [31:0] LIMIT_KEEP = 32'hFFFF_FFE3;
  localparam logic [31:0] TYPE_VAL   = 32'(NUM_REGIONS & 8'hFF);

  logic hit_ctrl, hit_type, hit_sel, hit_base, hit_limit, known;
  logic sec_wr, sec_rd, sel_ok, wdata_ok;
  logic [1:0]       ctrl_q;
  logic [SEL_W-1:0] sel_q;
  logic [31:0]      cur_base, cur_limit;

  assign hit_ctrl  = bus_off == OFF_CTRL;
  assign hit_type  = bus_off == OFF_TYPE;
  assign hit_sel   = bus_off == OFF_SEL;
  assign hit_base  = bus_off == OFF_BASE;
  assign hit_limit = bus_off == OFF_LIMIT;
  assign known     = hit_ctrl | hit_type | hit_sel | hit_base | hit_limit;

  assign sec_wr   = bus_wr & bus_secure;
  assign sec_rd   = bus_rd & bus_secure;
  assign sel_ok   = 32'(sel_q) < NUM_REGIONS;
  assign wdata_ok = bus_wdata < NUM_REGIONS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q         <= '0;
      sel_q          <= '0;
      region_changed <= 1'b0;
      sel_error      <= 1'b0;
    end else begin
      if (sec_wr && hit_ctrl) ctrl_q <= bus_wdata[1:0];
      if (sec_wr && hit_sel && wdata_ok) sel_q <= bus_wdata[SEL_W-1:0];
      region_changed <= sec_wr & (hit_base | hit_limit) & sel_ok;
      sel_error      <= sec_wr & hit_sel & ~wdata_ok;
    end
  end

  generate
    if (NUM_REGIONS > 0) begin : g_store
      logic [31:0] base_q  [NUM_REGIONS];
      logic [31:0] limit_q [NUM_REGIONS];
      logic [IDX_W-1:0] idx;
      assign idx = sel_q[IDX_W-1:0];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < int'(NUM_REGIONS); i++) begin
            base_q[i]  <= '0;
            limit_q[i] <= '0;
          end
        end else if (sec_wr && sel_ok) begin
          if (hit_base)  base_q[idx]  <= bus_wdata & BASE_KEEP;
          if (hit_limit) limit_q[idx] <= bus_wdata & LIMIT_KEEP;
        end
      end

      assign cur_base  = sel_ok ? base_q[idx]  : '0;
      assign cur_limit = sel_ok ? limit_q[idx] : '0;
    end else begin : g_empty
      assign cur_base  = '0;
      assign cur_limit = '0;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (sec_rd) begin
      if (hit_ctrl)       bus_rdata = {30'b0, ctrl_q};
      else if (hit_type)  bus_rdata = TYPE_VAL;
      else if (hit_sel)   bus_rdata = 32'(sel_q);
      else if (hit_base)  bus_rdata = cur_base;
      else if (hit_limit) bus_rdata = cur_limit;
    end
  end

  assign bad_offset = (bus_rd | bus_wr) & ~known;

  p_ns_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_secure) |-> bus_rdata == 32'b0);

  p_ns_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_secure) |=> ($stable(ctrl_q) && $stable(sel_q) && !region_changed && !sel_error));

  p_ctrl_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_rd && bus_off == OFF_CTRL) |-> bus_rdata[31:2] == 30'b0);

  p_type_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_rd && bus_off == OFF_TYPE) |-> bus_rdata == NUM_REGIONS);

  p_sel_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_secure && bus_off == OFF_SEL && bus_wdata >= NUM_REGIONS) |=> ($stable(sel_q) && sel_error));

  p_sel_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel_q) < NUM_REGIONS) || (sel_q == '0));

  p_base_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_rd && bus_off == OFF_BASE) |-> bus_rdata[4:0] == 5'b0);

  p_limit_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_rd && bus_off == OFF_LIMIT) |-> bus_rdata[4:2] == 3'b0);

  p_chg_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    region_changed |-> $past(bus_wr && bus_secure && (bus_off == OFF_BASE || bus_off == OFF_LIMIT)));

  p_bad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_offset |-> bus_rdata == 32'b0);

endmodule

// File: tb/sau_reg_bank_tb.sv
module sau_reg_bank_tb_top;
  localparam int unsigned N = 8;
  localparam logic [9:0] O_CTRL = 10'h374, O_TYPE = 10'h375, O_SEL = 10'h376,
                         O_BASE = 10'h377, O_LIMIT = 10'h378;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, bus_secure = 1'b0;
  logic [9:0]  bus_off = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_z;
  logic bad, bad_z, chg, chg_z, serr, serr_z;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] d;
    logic        bad;
    logic [31:0] dz;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  sau_reg_bank #(.NUM_REGIONS(N), .OFF_W(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(rdata),
    .bad_offset(bad), .region_changed(chg), .sel_error(serr));

  sau_reg_bank #(.NUM_REGIONS(0), .OFF_W(10)) dut_z (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(rdata_z),
    .bad_offset(bad_z), .region_changed(chg_z), .sel_error(serr_z));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected read", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check({it.tag, " rdata"}, rdata, it.d);
        check({it.tag, " bad_offset"}, 32'(bad), 32'(it.bad));
        check({it.tag, " zero-region rdata"}, rdata_z, it.dz);
      end
    end
  end

  task automatic rd(input logic [9:0] off, input logic sec, input logic [31:0] exp,
                    input logic exp_bad, input string tag);
    item_t it;
    @(posedge clk); #2;
    it.d = exp; it.bad = exp_bad; it.tag = tag;
    it.dz = (off == O_CTRL) ? exp : 32'd0;
    exp_q.push_back(it);
    bus_off = off; bus_secure = sec; bus_rd = 1'b1;
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [9:0] off, input logic [31:0] data, input logic sec);
    @(posedge clk); #2;
    bus_off = off; bus_wdata = data; bus_secure = sec; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R8 region_changed after reset", 32'(chg), 32'd0);
    check("R8 sel_error after reset", 32'(serr), 32'd0);
    rd(O_CTRL, 1, 0, 0, "R8 ctrl reset");
    rd(O_SEL, 1, 0, 0, "R8 selector reset");
    rd(O_BASE, 1, 0, 0, "R8 base reset");
    rd(O_LIMIT, 1, 0, 0, "R8 limit reset");

    rd(O_TYPE, 1, N, 0, "R4 R1 type value");
    wr(O_TYPE, 32'hFF, 1);
    rd(O_TYPE, 1, N, 0, "R4 type after write");

    wr(O_CTRL, 32'hFFFF_FFFF, 1);
    rd(O_CTRL, 1, 32'd3, 0, "R3 R1 ctrl mask");
    rd(O_CTRL, 0, 32'd0, 0, "R2 nonsecure ctrl read");
    wr(O_CTRL, 32'd0, 0);
    rd(O_CTRL, 1, 32'd3, 0, "R2 nonsecure ctrl write dropped");

    wr(O_SEL, 32'd5, 1);
    check("R5 sel_error on valid", 32'(serr), 32'd0);
    rd(O_SEL, 1, 32'd5, 0, "R5 R1 selector readback");
    wr(O_BASE, 32'h1234_567F, 1);
    check("R9 pulse after base write", 32'(chg), 32'd1);
    check("R11 zero-region no pulse", 32'(chg_z), 32'd0);
    @(posedge clk); #2;
    check("R9 pulse one cycle", 32'(chg), 32'd0);
    rd(O_BASE, 1, 32'h1234_5660, 0, "R7 R1 base mask");
    wr(O_LIMIT, 32'hABCD_EFFF, 1);
    check("R9 pulse after limit write", 32'(chg), 32'd1);
    rd(O_LIMIT, 1, 32'hABCD_EFE3, 0, "R7 R1 limit mask");

    wr(O_SEL, N, 1);
    check("R5 sel_error on out of range", 32'(serr), 32'd1);
    check("R9 no pulse on selector write", 32'(chg), 32'd0);
    @(posedge clk); #2;
    check("R5 sel_error one cycle", 32'(serr), 32'd0);
    rd(O_SEL, 1, 32'd5, 0, "R5 selector kept");
    wr(O_SEL, 32'hFF, 1);
    rd(O_SEL, 1, 32'd5, 0, "R5 selector kept after 255");

    wr(O_SEL, 32'd2, 1);
    wr(O_BASE, 32'h0000_0100, 1);
    rd(O_BASE, 1, 32'h0000_0100, 0, "R6 region 2 base");
    rd(O_LIMIT, 1, 32'd0, 0, "R6 region 2 limit untouched");
    wr(O_SEL, N - 1, 1);
    wr(O_LIMIT, 32'h8000_0003, 1);
    rd(O_LIMIT, 1, 32'h8000_0003, 0, "R6 R5 top region limit");
    wr(O_SEL, 32'd5, 1);
    rd(O_BASE, 1, 32'h1234_5660, 0, "R6 region 5 base kept");

    wr(O_BASE, 32'hFFFF_FFFF, 0);
    check("R2 no pulse on nonsecure write", 32'(chg), 32'd0);
    rd(O_BASE, 1, 32'h1234_5660, 0, "R2 base after nonsecure write");
    rd(O_BASE, 0, 32'd0, 0, "R2 nonsecure base read");
    wr(O_SEL, 32'd1, 0);
    rd(O_SEL, 1, 32'd5, 0, "R2 selector after nonsecure write");

    rd(10'h379, 1, 32'd0, 1, "R10 read past limit offset");
    rd(10'h373, 1, 32'd0, 1, "R10 read below ctrl offset");
    @(posedge clk); #2;
    bus_off = 10'h000; bus_wdata = 32'hFFFF_FFFF; bus_secure = 1'b1; bus_wr = 1'b1;
    #8;
    check("R10 bad_offset on write", 32'(bad), 32'd1);
    @(posedge clk); #2;
    bus_wr = 1'b0;
    rd(O_CTRL, 1, 32'd3, 0, "R10 ctrl unaffected");

    wr(O_SEL, 32'd0, 1);
    check("R11 zero-region rejects selector", 32'(serr_z), 32'd1);
    check("R5 zero accepted with regions", 32'(serr), 32'd0);
    wr(O_BASE, 32'h4000_0000, 1);
    check("R11 zero-region base write no pulse", 32'(chg_z), 32'd0);
    rd(O_BASE, 1, 32'h4000_0000, 0, "R11 R6 base region 0");

    do_reset();
    rd(O_CTRL, 1, 0, 0, "R8 ctrl after second reset");
    wr(O_SEL, 32'd5, 1);
    rd(O_BASE, 1, 0, 0, "R8 base cleared by reset");
    rd(O_LIMIT, 1, 0, 0, "R8 limit cleared by reset");

    repeat (2) @(posedge clk);
    check("R12 all expected reads seen", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule